// File: doc/BRIEF.md
# Bus Transaction Trace Capture Buffer

This block observes a memory-interconnect command bus and stores a selection of its transactions into a small on-chip trace memory. Software drains that memory through a register port. Every bus beat carries an opcode, a requester number, a target number and a 40-bit address. A capture filter decides which beats are stored. Two trigger matchers, built the same way as the filter, can start and stop a recording session and leave sticky hit flags behind.

Each stored entry is 128 bits wide and is read as two 64-bit halves. It holds a valid flag, a discontinuity flag, a coarse 16-bit timestamp, the opcode, the source, the destination and the address. The timestamp is a free-running cycle count scaled down by a programmable power of eight. When the memory is full, qualifying beats are dropped, and the next entry that is stored carries the discontinuity flag.

Register map (64-bit words, byte offsets):
- 0x00 control: bit0 enable, bit1 start-on-trigger-0, bit2 stop-on-trigger-1, bits5:4 granularity, bit6 split-read.
- 0x08 status: bit0 trigger-0 hit, bit1 trigger-1 hit, bit2 armed. Writing a 1 to bit0 or bit1 clears that hit.
- 0x10 entry low half. Reading it pops the entry.
- 0x18 entry high half.
- 0x40 capture filter, 0x80 trigger 0, 0xC0 trigger 1. Each of these sets holds: +0x00 opcode mask, +0x08 source mask, +0x10 destination mask, +0x18 address compare, +0x20 address mask.

Top module: `xact_trace_capture`

## Requirements
- R1: A beat is captured only if bit `opcode` of the filter's opcode mask is set. An all-ones mask passes every opcode.
- R2: Bit `source` of the 64-bit source mask and bit `destination` of the 32-bit destination mask must both be set for capture.
- R3: Only address bits where the address mask is 1 are compared with the compare value. An all-zero mask passes every address.
- R4: While a set's address mask is nonzero, opcode 15 (asynchronous DMA) never matches in that set, even if its opcode bit is set.
- R5: The low half is {addr[31:0] at bits 63:32, 2'b00, source at 29:24, opcode at 23:18, stamp at 17:2, discontinuity at bit1, valid at bit0}. The high half is {destination at bits 12:8, addr[39:32] at bits 7:0}. With split-read (control bit6) set, reading 0x18 returns the high half of the entry popped by the last 0x10 read. With it clear, 0x18 reads 0.
- R6: Reading 0x10 returns the oldest entry and removes it. When the memory is empty, the read returns all zeros (valid bit 0) and changes nothing.
- R7: The stamp equals (cycles since reset >> (3 * granularity)), truncated to 16 bits, taken in the cycle the beat is presented.
- R8: With DEPTH entries held, qualifying beats are dropped and stored entries are unchanged. The next stored entry has the discontinuity flag, and later entries do not.
- R9: A beat matching trigger set 0 or 1 sets status bit0 or bit1, whatever the enable. The bit stays set until a 1 is written to it.
- R10: With start-on-trigger-0 set, nothing is captured before the first trigger-0 match. The matching beat itself is captured if the filter passes it.
- R11: With stop-on-trigger-1 set, the trigger-1 beat is still captured and later beats are not. Writing the control register re-arms the session.
- R12: With enable clear, no beat is captured.
- R13: After reset, control, status and both entry halves read 0, and every mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Bus beat present this cycle |
| busOp | input | 6 | Beat opcode |
| busSrc | input | 6 | Requester number |
| busDst | input | 5 | Target number |
| busAddr | input | 40 | Beat address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops on 0x10) |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data, combinational on regAddr |

## Verification
The bench goes after the full boundary. A design that frees a slot too early or overwrites the oldest entry would return entries out of order, and one that forgets the pending gap would leave the discontinuity flag clear on the first entry after the drain. It checks that the DMA opcode is refused only while an address mask is set. A design that always blocks it, or never blocks it, gives the wrong entry count. It also checks the edges of the trigger session. A design that drops the starting or stopping beat, or keeps recording after the stop, leaves a mismatch in the entry queue. Timestamp scaling is checked at a nonzero granularity, where a wrong shift gives a different stamp.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int OP_W     = 6;
  localparam int SRC_W    = 6;
  localparam int DST_W    = 5;
  localparam int ADDR_W   = 40;
  localparam int TS_W     = 16;
  localparam int REG_W    = 64;
  localparam int GRAN_W   = 2;
  localparam int SET_N    = 3;
  localparam int OP_N     = 1 << OP_W;
  localparam int SRC_N    = 1 << SRC_W;
  localparam int DST_N    = 1 << DST_W;
  localparam int TSC_W    = TS_W + 3 * ((1 << GRAN_W) - 1);
  localparam int HI_ADR_W = ADDR_W - 32;
  localparam int LO_OP_POS  = 2 + TS_W;
  localparam int LO_SRC_POS = LO_OP_POS + OP_W;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_DLO  = 8'h10;
  localparam logic [7:0] OFS_DHI  = 8'h18;

  typedef struct packed {
    logic [OP_N-1:0]   opMask;
    logic [SRC_N-1:0]  srcMask;
    logic [DST_N-1:0]  dstMask;
    logic [ADDR_W-1:0] addrCmp;
    logic [ADDR_W-1:0] addrMsk;
  } match_cfg_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic markDisc;
    logic latchHi;
  } dp_strobe_t;

  typedef struct packed {
    logic              disc;
    logic [TS_W-1:0]   stamp;
    logic [OP_W-1:0]   op;
    logic [SRC_W-1:0]  src;
    logic [DST_W-1:0]  dst;
    logic [ADDR_W-1:0] addr;
  } entry_t;

  function automatic logic [REG_W-1:0] packLo(entry_t e);
    logic [REG_W-1:0] w;
    w = '0;
    w[0] = 1'b1;
    w[1] = e.disc;
    w[2 +: TS_W] = e.stamp;
    w[LO_OP_POS +: OP_W] = e.op;
    w[LO_SRC_POS +: SRC_W] = e.src;
    w[REG_W-32 +: 32] = e.addr[31:0];
    return w;
  endfunction

  function automatic logic [REG_W-1:0] packHi(entry_t e);
    logic [REG_W-1:0] w;
    w = '0;
    w[0 +: HI_ADR_W] = e.addr[ADDR_W-1:32];
    w[HI_ADR_W +: DST_W] = e.dst;
    return w;
  endfunction
endpackage

// File: rtl/trc_matcher.sv
module trc_matcher
  import trc_pkg::*;
#(
  parameter int DMA_OP = 15
) (
  input  match_cfg_t        cfg,
  input  logic [OP_W-1:0]   op,
  input  logic [SRC_W-1:0]  src,
  input  logic [DST_W-1:0]  dst,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [OP_N-1:0] opEff;
  logic            addrOk;

  // DMA beats are refused whenever address comparison is in use
  always_comb begin
    opEff = cfg.opMask;
    if (|cfg.addrMsk) opEff[DMA_OP] = 1'b0;
  end

  assign addrOk = ~|((addr ^ cfg.addrCmp) & cfg.addrMsk);
  assign hit = opEff[op] & cfg.srcMask[src] & cfg.dstMask[dst] & addrOk;
endmodule

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DMA_OP = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [OP_W-1:0]         busOp,
  input  logic [SRC_W-1:0]        busSrc,
  input  logic [DST_W-1:0]        busDst,
  input  logic [ADDR_W-1:0]       busAddr,
  input  match_cfg_t [SET_N-1:0]  cfgSet,
  input  logic [GRAN_W-1:0]       gran,
  input  dp_strobe_t              stb,
  output logic [SET_N-1:0]        setHit,
  output logic                    full,
  output logic                    empty,
  output logic [REG_W-1:0]        dataLo,
  output logic [REG_W-1:0]        dataHi
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  entry_t           mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [TSC_W-1:0] tsCnt;
  logic [TSC_W-1:0] tsShift;
  logic [4:0]       shAmt;
  entry_t           newEntry;
  logic [REG_W-1:0] hiLatch;

  for (genvar g = 0; g < SET_N; g++) begin : g_match
    trc_matcher #(.DMA_OP(DMA_OP)) u_match (
      .cfg (cfgSet[g]),
      .op  (busOp),
      .src (busSrc),
      .dst (busDst),
      .addr(busAddr),
      .hit (setHit[g])
    );
  end

  // free-running stamp source, scaled by 8^gran
  always_ff @(posedge clk) begin
    if (rst) tsCnt <= '0;
    else     tsCnt <= tsCnt + 1'b1;
  end

  assign shAmt   = 5'(gran) * 5'd3;
  assign tsShift = tsCnt >> shAmt;

  always_comb begin
    newEntry.disc  = stb.markDisc;
    newEntry.stamp = tsShift[TS_W-1:0];
    newEntry.op    = busOp;
    newEntry.src   = busSrc;
    newEntry.dst   = busDst;
    newEntry.addr  = busAddr;
  end

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (stb.push && !stb.pop)      count <= count + 1'b1;
      else if (stb.pop && !stb.push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              hiLatch <= '0;
    else if (stb.latchHi) hiLatch <= empty ? '0 : packHi(mem[rdPtr]);
  end

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign dataLo = empty ? '0 : packLo(mem[rdPtr]);
  assign dataHi = hiLatch;
endmodule

// File: rtl/trc_control.sv
module trc_control
  import trc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busValid,
  input  logic                    regWrEn,
  input  logic                    regRdEn,
  input  logic [7:0]              regAddr,
  input  logic [REG_W-1:0]        regWdata,
  output logic [REG_W-1:0]        regRdata,
  input  logic [SET_N-1:0]        setHit,
  input  logic                    full,
  input  logic                    empty,
  input  logic [REG_W-1:0]        dataLo,
  input  logic [REG_W-1:0]        dataHi,
  output match_cfg_t [SET_N-1:0]  cfgSet,
  output logic [GRAN_W-1:0]       gran,
  output dp_strobe_t              stb,
  output logic                    capEnable,
  output logic [1:0]              trigHits
);
  logic       aligned;
  logic [2:0] wordSel;
  logic [1:0] setSel;
  logic       ctrlWr, statWr, rdLo;
  logic       startMode, stopMode, splitMode;
  logic       startedQ, stoppedQ, discPend;
  logic       t0Now, t1Now, active, armed, capReq, drop;

  assign aligned = (regAddr[2:0] == 3'b000);
  assign wordSel = regAddr[5:3];
  assign setSel  = regAddr[7:6];
  assign ctrlWr  = regWrEn && (regAddr == OFS_CTRL);
  assign statWr  = regWrEn && (regAddr == OFS_STAT);
  assign rdLo    = regRdEn && (regAddr == OFS_DLO);

  // one register set per matcher: 1=filter, 2=trigger0, 3=trigger1
  for (genvar g = 0; g < SET_N; g++) begin : g_cfg
    match_cfg_t cfgQ;
    always_ff @(posedge clk) begin
      if (rst) cfgQ <= '0;
      else if (regWrEn && aligned && (setSel == 2'(g + 1))) begin
        case (wordSel)
          3'd0: cfgQ.opMask  <= regWdata[OP_N-1:0];
          3'd1: cfgQ.srcMask <= regWdata[SRC_N-1:0];
          3'd2: cfgQ.dstMask <= regWdata[DST_N-1:0];
          3'd3: cfgQ.addrCmp <= regWdata[ADDR_W-1:0];
          3'd4: cfgQ.addrMsk <= regWdata[ADDR_W-1:0];
          default: ;
        endcase
      end
    end
    assign cfgSet[g] = cfgQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capEnable <= 1'b0;
      startMode <= 1'b0;
      stopMode  <= 1'b0;
      gran      <= '0;
      splitMode <= 1'b0;
    end else if (ctrlWr) begin
      capEnable <= regWdata[0];
      startMode <= regWdata[1];
      stopMode  <= regWdata[2];
      gran      <= regWdata[5:4];
      splitMode <= regWdata[6];
    end
  end

  // session window: optional start on trigger 0, optional stop on trigger 1
  assign t0Now  = busValid && setHit[1];
  assign t1Now  = busValid && setHit[2];
  assign armed  = capEnable && (!startMode || startedQ) && !stoppedQ;
  assign active = capEnable && (!startMode || startedQ || t0Now) && !stoppedQ;
  assign capReq = busValid && setHit[0] && active;
  assign drop   = capReq && full;

  always_ff @(posedge clk) begin
    if (rst || ctrlWr) begin
      startedQ <= 1'b0;
      stoppedQ <= 1'b0;
    end else begin
      if (capEnable && startMode && t0Now) startedQ <= 1'b1;
      if (active && stopMode && t1Now)     stoppedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           discPend <= 1'b0;
    else if (drop)     discPend <= 1'b1;
    else if (stb.push) discPend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) trigHits <= '0;
    else trigHits <= (trigHits & ~(statWr ? regWdata[1:0] : 2'b00))
                   | {t1Now, t0Now};
  end

  always_comb begin
    stb.push     = capReq && !full;
    stb.pop      = rdLo && !empty;
    stb.markDisc = discPend;
    stb.latchHi  = rdLo;
  end

  always_comb begin
    regRdata = '0;
    if (aligned) begin
      case (setSel)
        2'd0: begin
          case (wordSel)
            3'd0: regRdata = REG_W'({splitMode, gran, 1'b0, stopMode, startMode, capEnable});
            3'd1: regRdata = REG_W'({armed, trigHits});
            3'd2: regRdata = dataLo;
            3'd3: regRdata = splitMode ? dataHi : '0;
            default: regRdata = '0;
          endcase
        end
        default: begin
          case (wordSel)
            3'd0: regRdata = REG_W'(cfgSet[setSel - 2'd1].opMask);
            3'd1: regRdata = REG_W'(cfgSet[setSel - 2'd1].srcMask);
            3'd2: regRdata = REG_W'(cfgSet[setSel - 2'd1].dstMask);
            3'd3: regRdata = REG_W'(cfgSet[setSel - 2'd1].addrCmp);
            3'd4: regRdata = REG_W'(cfgSet[setSel - 2'd1].addrMsk);
            default: regRdata = '0;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/xact_trace_capture.sv
module xact_trace_capture
  import trc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DMA_OP = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic [5:0]        busOp,
  input  logic [5:0]        busSrc,
  input  logic [4:0]        busDst,
  input  logic [39:0]       busAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [63:0]       regWdata,
  output logic [63:0]       regRdata
);
  match_cfg_t [SET_N-1:0] cfgSet;
  logic [GRAN_W-1:0]      gran;
  dp_strobe_t             stb;
  logic [SET_N-1:0]       setHit;
  logic                   full, empty;
  logic [REG_W-1:0]       dataLo, dataHi;
  logic                   capEnable;
  logic [1:0]             trigHits;

  trc_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busValid (busValid),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .setHit   (setHit),
    .full     (full),
    .empty    (empty),
    .dataLo   (dataLo),
    .dataHi   (dataHi),
    .cfgSet   (cfgSet),
    .gran     (gran),
    .stb      (stb),
    .capEnable(capEnable),
    .trigHits (trigHits)
  );

  trc_datapath #(.DEPTH(DEPTH), .DMA_OP(DMA_OP)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .busOp  (busOp),
    .busSrc (busSrc),
    .busDst (busDst),
    .busAddr(busAddr),
    .cfgSet (cfgSet),
    .gran   (gran),
    .stb    (stb),
    .setHit (setHit),
    .full   (full),
    .empty  (empty),
    .dataLo (dataLo),
    .dataHi (dataHi)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker
  import trc_pkg::*;
#(
  parameter int DMA_OP = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              busValid,
  input logic [5:0]        busOp,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [7:0]        regAddr,
  input logic [63:0]       regWdata,
  input logic [63:0]       regRdata,
  input dp_strobe_t        stb,
  input logic              full,
  input logic              empty,
  input logic              capEnable,
  input logic [1:0]        trigHits,
  input logic              filtHit,
  input logic              filtMskNz
);
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (rst)
    stb.push |-> !full);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == 8'h10 && empty) |-> (regRdata == 64'd0));

  assert_hit_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (trigHits[0] && !(regWrEn && regAddr == 8'h08 && regWdata[0])) |=> trigHits[0]);

  assert_disabled_no_push_R12: assert property (@(posedge clk) disable iff (rst)
    !capEnable |-> !stb.push);

  assert_dma_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    (busValid && busOp == 6'(DMA_OP) && filtMskNz) |-> !filtHit);
endmodule

bind xact_trace_capture trc_checker #(.DMA_OP(DMA_OP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busValid (busValid),
  .busOp    (busOp),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .stb      (stb),
  .full     (full),
  .empty    (empty),
  .capEnable(capEnable),
  .trigHits (trigHits),
  .filtHit  (setHit[0]),
  .filtMskNz(|cfgSet[0].addrMsk)
);

// File: tb/xact_trace_capture_test.sv
module xact_trace_capture_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0;
  logic [5:0]  busOp = '0;
  logic [5:0]  busSrc = '0;
  logic [4:0]  busDst = '0;
  logic [39:0] busAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;

  always #2 clk = ~clk;

  xact_trace_capture uut (
    .clk(clk), .rst(rst), .busValid(busValid), .busOp(busOp), .busSrc(busSrc),
    .busDst(busDst), .busAddr(busAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  typedef struct { logic [63:0] lo; logic [63:0] hi; } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit discPend = 0;
  int gran = 0;
  bit split = 0;
  longint unsigned cyc;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic setCtrl(logic [63:0] v);
    wr(8'h00, v);
    gran = int'(v[5:4]);
    split = v[6];
  endtask

  task automatic setMatch(logic [7:0] base, logic [63:0] op, logic [63:0] src,
                          logic [63:0] dst, logic [63:0] cmp, logic [63:0] msk);
    wr(base + 8'h00, op);
    wr(base + 8'h08, src);
    wr(base + 8'h10, dst);
    wr(base + 8'h18, cmp);
    wr(base + 8'h20, msk);
  endtask

  // driver: presents one beat and records the entry the model expects
  task automatic send(int op, int src, int dst, logic [39:0] addr, bit expCap);
    exp_t e;
    logic [15:0] stamp;
    busOp = 6'(op); busSrc = 6'(src); busDst = 5'(dst); busAddr = addr;
    busValid = 1'b1;
    if (expCap) begin
      if (q.size() == DEPTH) discPend = 1;
      else begin
        stamp = 16'(cyc >> (3 * gran));
        e.lo = {addr[31:0], 2'b00, 6'(src), 6'(op), stamp, discPend, 1'b1};
        e.hi = {51'd0, 5'(dst), addr[39:32]};
        discPend = 0;
        q.push_back(e);
      end
    end
    @(negedge clk);
    busValid = 1'b0;
  endtask

  // monitor: pops entries from the design and compares with the queue
  task automatic drain(string req, int n);
    logic [63:0] lo, hi;
    exp_t e;
    for (int i = 0; i < n; i++) begin
      rd(8'h10, lo);
      if (q.size() == 0) begin
        chk(req, lo, 64'd0);
      end else begin
        e = q.pop_front();
        chk(req, lo, e.lo);
        rd(8'h18, hi);
        chk(req, hi, split ? e.hi : 64'd0);
      end
    end
  endtask

  task automatic expectEmpty(string req);
    logic [63:0] lo;
    rd(8'h10, lo);
    chk(req, lo, 64'd0);
  endtask

  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ALL32 = 64'h0000_0000_FFFF_FFFF;

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    rd(8'h00, v); chk("R13 ctrl", v, 64'd0);
    rd(8'h08, v); chk("R13 status", v, 64'd0);
    rd(8'h18, v); chk("R13 hi", v, 64'd0);
    rd(8'h40, v); chk("R13 mask", v, 64'd0);
    expectEmpty("R6 R13 empty read");

    // R1 R2 R5 R7: open filter, several beats
    setMatch(8'h40, ALL, ALL, ALL32, 64'd0, 64'd0);
    setCtrl(64'h41);
    send(3, 1, 2, 40'h12_3456_789A, 1);
    send(63, 63, 31, 40'hFF_FFFF_FFFF, 1);
    send(0, 0, 0, 40'h00_0000_0010, 1);
    drain("R5 R7 open filter", 3);
    expectEmpty("R6 empty after drain");

    // R1 opcode mask
    wr(8'h40, (64'd1 << 3) | (64'd1 << 20));
    send(3, 4, 4, 40'h1, 1);
    send(4, 4, 4, 40'h2, 0);
    send(20, 4, 4, 40'h3, 1);
    drain("R1 opcode mask", 2);
    expectEmpty("R1 masked opcode ignored");

    // R2 source and destination masks
    setMatch(8'h40, ALL, 64'd1 << 5, 64'd1 << 31, 64'd0, 64'd0);
    send(9, 5, 31, 40'h4, 1);
    send(9, 5, 30, 40'h5, 0);
    send(9, 6, 31, 40'h6, 0);
    drain("R2 src/dst mask", 1);
    expectEmpty("R2 masked beats ignored");

    // R3 R4 address compare and DMA suppression
    setMatch(8'h40, ALL, ALL, ALL32, 64'hAB_CD00_0000, 64'hFF_FF00_0000);
    send(2, 7, 3, 40'hAB_CD12_3456, 1);
    send(2, 7, 3, 40'hAB_CE00_0000, 0);
    send(15, 7, 3, 40'hAB_CD12_3456, 0);
    drain("R3 address compare", 1);
    expectEmpty("R4 DMA blocked with address mask");
    wr(8'h60, 64'd0);
    send(15, 7, 3, 40'hAB_CE00_0000, 1);
    drain("R4 DMA passes with zero mask", 1);

    // R7 granularity
    setCtrl(64'h61);
    send(5, 2, 2, 40'h77, 1);
    drain("R7 gran 2 stamp", 1);
    setCtrl(64'h71);
    send(6, 2, 2, 40'h78, 1);
    drain("R7 gran 3 stamp", 1);

    // R5 split-read off: high half reads zero
    setCtrl(64'h01);
    send(8, 9, 10, 40'hAA_0000_0001, 1);
    drain("R5 split off", 1);

    // R8 full buffer and discontinuity
    setCtrl(64'h41);
    for (int i = 0; i < DEPTH + 2; i++) send(i % 64, i % 64, i % 32, 40'(i * 8), 1);
    drain("R8 full contents", DEPTH);
    send(1, 1, 1, 40'h100, 1);
    send(2, 2, 2, 40'h200, 1);
    drain("R8 discontinuity", 2);
    expectEmpty("R8 empty");

    // R9 R12 triggers while disabled
    setMatch(8'h80, 64'd1 << 7, ALL, ALL32, 64'd0, 64'd0);
    setMatch(8'hC0, 64'd1 << 9, ALL, ALL32, 64'd0, 64'd0);
    setCtrl(64'h40);
    send(1, 3, 3, 40'h10, 0);
    send(7, 3, 3, 40'h11, 0);
    rd(8'h08, v); chk("R9 trigger0 hit", v, 64'd1);
    expectEmpty("R12 disabled captures nothing");
    @(negedge clk);
    rd(8'h08, v); chk("R9 hit sticky", v, 64'd1);
    wr(8'h08, 64'd1);
    rd(8'h08, v); chk("R9 hit cleared", v, 64'd0);

    // R10 start on trigger 0
    setCtrl(64'h43);
    send(1, 3, 3, 40'h20, 0);
    send(7, 3, 3, 40'h21, 1);
    send(2, 3, 3, 40'h22, 1);
    drain("R10 start on trigger", 2);
    expectEmpty("R10 nothing before trigger");

    // R11 stop on trigger 1
    setCtrl(64'h45);
    send(1, 4, 4, 40'h30, 1);
    send(9, 4, 4, 40'h31, 1);
    send(2, 4, 4, 40'h32, 0);
    rd(8'h08, v); chk("R11 R9 status after stop", v, 64'd3);
    drain("R11 stop on trigger", 2);
    expectEmpty("R11 nothing after stop");
    setCtrl(64'h45);
    send(3, 4, 4, 40'h33, 1);
    drain("R11 rearm", 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule